// File: doc/BRIEF.md
# Homogeneous NFA State Array

This block is a bank of automaton states that all look at the same 8-bit input symbol on each clock cycle. Each state holds its own 256-entry set of accepted symbols, a single active bit, a start mode and a report flag. A routing matrix records which states each state enables when it matches. A state that matches a symbol enables its successors for the next symbol. Self-loops and any pattern of fan-in or fan-out are allowed. This lets one array run many small non-deterministic automata side by side, for example to scan a flattened record stream for many candidate patterns at once.

The array is loaded through a word-wide configuration port while the stream is idle. A stream is then presented one symbol per valid cycle, with a start-of-data pulse on its first symbol. One cycle after each symbol, the array presents a report vector marking every reporting state that matched. A strobe marks the cycles on which that vector is non-empty.

Top module: `nfa_state_array`

## Requirements
- R1: A synchronous reset clears every active flag, drives `rpt_valid` low and `rpt_vec` to zero, and returns the configuration to its empty state: all symbol masks zero, no routes, mode on-activation, and no report flags.
- R2: The array advances only on cycles with `sym_valid` high. On other cycles the active flags hold their values, and in the following cycle `rpt_valid` is low and `rpt_vec` is zero.
- R3: A state matches a valid symbol exactly when the mask bit indexed by the symbol value is set and the state is enabled in that cycle. After that symbol, its active flag equals that match.
- R4: The mode field selects the enable source. 2'b01 enables the state on the first symbol of a stream. 2'b10 enables it on every symbol. 2'b00 and 2'b11 enable it only through an active predecessor. A predecessor can enable a state in any mode.
- R5: Route row i, bit j set means that state i, while active, enables state j for the next symbol. Enables from several predecessors are ORed, and a state may route to itself.
- R6: A symbol presented with `sym_first` high is evaluated as if all active flags were clear, so predecessor enables from the previous stream have no effect on it.
- R7: One cycle after a valid symbol, bit i of `rpt_vec` is 1 exactly when state i matched and its report flag is set. `rpt_valid` is high exactly when at least one bit is set, and `rpt_vec` is all zero whenever `rpt_valid` is low.
- R8: A configuration write is selected by `cfg_kind`. 2'b00 writes `cfg_wdata` into mask bits [32*`cfg_word` +: 32] of state `cfg_idx`. 2'b01 writes route row `cfg_idx` from `cfg_wdata`[N-1:0]. 2'b10 writes the mode from `cfg_wdata`[1:0] and the report flag from `cfg_wdata`[2]. 2'b11 writes nothing.
- R9: A configuration write issued in a cycle with `sym_valid` high is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | A symbol is presented this cycle |
| sym_first | input | 1 | The presented symbol starts a new stream |
| sym_data | input | 8 | Input symbol |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Configuration target: mask word, route row, attributes |
| cfg_idx | input | 3 | State index written |
| cfg_word | input | 3 | Mask word index within the 256-bit mask |
| cfg_wdata | input | 32 | Configuration write data |
| rpt_valid | output | 1 | At least one reporting state matched the previous symbol |
| rpt_vec | output | 8 | One bit per state that matched and reports |

## Verification
A wrong active flag does not show at the ports right away. It first appears one symbol later, as a report from a successor that should or should not have been enabled, so the bench drives symbol chains whose second and third steps depend on the exact active set. A wrong mask or mode bit shows on the report of the very symbol that exercises it. A wrong configuration store shows as a missing or extra report on the first symbol that uses the affected state. Stream restarts and idle gaps are placed so that a flag that is kept or dropped when it should not be changes the next report.

// File: rtl/nfa_pkg.sv
package nfa_pkg;

  typedef enum logic [1:0] {
    MODE_ON_ACT = 2'b00,
    MODE_FIRST  = 2'b01,
    MODE_ALL    = 2'b10,
    MODE_RSVD   = 2'b11
  } start_mode_e;

  typedef enum logic [1:0] {
    CFG_MASK  = 2'b00,
    CFG_ROUTE = 2'b01,
    CFG_ATTR  = 2'b10,
    CFG_NONE  = 2'b11
  } cfg_kind_e;

  // Enable source selection; pred is already gated off on a stream start.
  function automatic logic state_enabled(input logic [1:0] mode,
                                         input logic       first,
                                         input logic       pred);
    logic en;
    case (mode)
      MODE_ALL:   en = 1'b1;
      MODE_FIRST: en = first | pred;
      default:    en = pred;
    endcase
    return en;
  endfunction

  // Attribute word layout: [1:0] mode, [2] report flag.
  function automatic logic [1:0] attr_mode(input logic [2:0] w);
    return w[1:0];
  endfunction

  function automatic logic attr_report(input logic [2:0] w);
    return w[2];
  endfunction

endpackage

// File: rtl/nfa_cfg_store.sv
module nfa_cfg_store #(
  parameter int N_STATES = 8,
  parameter int SYM_W    = 8,
  parameter int CFG_W    = 32,
  localparam int NSYM    = 1 << SYM_W,
  localparam int WORDS   = NSYM / CFG_W,
  localparam int IDX_W   = (N_STATES > 1) ? $clog2(N_STATES) : 1,
  localparam int WSEL_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cfg_we,
  input  logic [1:0]                         cfg_kind,
  input  logic [IDX_W-1:0]                   cfg_idx,
  input  logic [WSEL_W-1:0]                  cfg_word,
  input  logic [CFG_W-1:0]                   cfg_wdata,
  input  logic                               stream_busy,
  output logic [N_STATES-1:0][NSYM-1:0]      masks,
  output logic [N_STATES-1:0][N_STATES-1:0]  routes,
  output logic [N_STATES-1:0][1:0]           modes,
  output logic [N_STATES-1:0]                rep_en
);
  import nfa_pkg::*;

  // Write accepted only while no symbol is in flight.
  logic cfg_accept;
  assign cfg_accept = cfg_we & ~stream_busy;

  logic [CFG_W-1:0]    mword_q [N_STATES][WORDS];
  logic [N_STATES-1:0] route_q [N_STATES];
  logic [1:0]          mode_q  [N_STATES];
  logic                rep_q   [N_STATES];

  for (genvar i = 0; i < N_STATES; i++) begin : g_state
    logic sel;
    assign sel = cfg_accept && (cfg_idx == IDX_W'(i));

    for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst) begin
          mword_q[i][w] <= '0;
        end else if (sel && cfg_kind == CFG_MASK && cfg_word == WSEL_W'(w)) begin
          mword_q[i][w] <= cfg_wdata;
        end
      end
      assign masks[i][w*CFG_W +: CFG_W] = mword_q[i][w];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        route_q[i] <= '0;
        mode_q[i]  <= MODE_ON_ACT;
        rep_q[i]   <= 1'b0;
      end else if (sel) begin
        case (cfg_kind)
          CFG_ROUTE: route_q[i] <= cfg_wdata[N_STATES-1:0];
          CFG_ATTR: begin
            mode_q[i] <= attr_mode(cfg_wdata[2:0]);
            rep_q[i]  <= attr_report(cfg_wdata[2:0]);
          end
          default: ;
        endcase
      end
    end

    assign routes[i] = route_q[i];
    assign modes[i]  = mode_q[i];
    assign rep_en[i] = rep_q[i];
  end

  // R9: writes that collide with a symbol leave the configuration unchanged.
  a_r9_cfg_blocked: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && stream_busy) |=> ($stable(modes) && $stable(rep_en) &&
                                 $stable(routes) && $stable(masks)));

  // R1: reset empties the attribute and route store.
  a_r1_cfg_reset: assert property (@(posedge clk)
    rst |=> (rep_en == '0 && routes == '0));

endmodule

// File: rtl/nfa_route_net.sv
module nfa_route_net #(
  parameter int N_STATES = 8
) (
  input  logic [N_STATES-1:0]               active,
  input  logic [N_STATES-1:0][N_STATES-1:0] routes,
  output logic [N_STATES-1:0]               pred_en
);
  // Column OR of the route matrix, masked by the source active bits.
  for (genvar j = 0; j < N_STATES; j++) begin : g_dst
    always_comb begin
      pred_en[j] = 1'b0;
      for (int i = 0; i < N_STATES; i++) begin
        pred_en[j] = pred_en[j] | (active[i] & routes[i][j]);
      end
    end
  end

  // R5: an enable never appears without some active source.
  always_comb begin
    if (active == '0) a_r5_no_source: assert (pred_en == '0);
  end

endmodule

// File: rtl/nfa_state_cell.sv
module nfa_state_cell #(
  parameter int SYM_W = 8,
  localparam int NSYM = 1 << SYM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid,
  input  logic             sym_first,
  input  logic [SYM_W-1:0] sym_data,
  input  logic [NSYM-1:0]  mask,
  input  logic [1:0]       mode,
  input  logic             pred_en,
  output logic             match,
  output logic             active_q
);
  import nfa_pkg::*;

  function automatic logic mask_hit(input logic [NSYM-1:0] m,
                                    input logic [SYM_W-1:0] s);
    return m[s];
  endfunction

  logic pred_live;
  logic enabled;
  assign pred_live = pred_en & ~sym_first;
  assign enabled   = state_enabled(mode, sym_first, pred_live);
  assign match     = sym_valid & enabled & mask_hit(mask, sym_data);

  always_ff @(posedge clk) begin
    if (rst)            active_q <= 1'b0;
    else if (sym_valid) active_q <= match;
  end

  // R2: no symbol, no change.
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !sym_valid |=> $stable(active_q));

  // R3: a symbol outside the mask cannot leave the state active.
  a_r3_mask_gate: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && !mask[sym_data]) |=> !active_q);

  // R6: on a stream start, an activation-only state stays off.
  a_r6_start_drops_pred: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_first && (mode == MODE_ON_ACT || mode == MODE_RSVD))
      |=> !active_q);

  // R4: an all-input state is always enabled, so a masked symbol activates it.
  a_r4_all_input: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && mode == MODE_ALL && mask[sym_data]) |=> active_q);

endmodule

// File: rtl/nfa_report.sv
module nfa_report #(
  parameter int N_STATES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sym_valid,
  input  logic [N_STATES-1:0] match,
  input  logic [N_STATES-1:0] rep_en,
  output logic                rpt_valid,
  output logic [N_STATES-1:0] rpt_vec
);
  logic [N_STATES-1:0] fire;
  logic                any_fire;
  assign fire     = match & rep_en;
  assign any_fire = |fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      rpt_valid <= 1'b0;
      rpt_vec   <= '0;
    end else begin
      rpt_valid <= sym_valid & any_fire;
      rpt_vec   <= sym_valid ? fire : '0;
    end
  end

  // R1: reset empties the report outputs.
  a_r1_report_reset: assert property (@(posedge clk)
    rst |=> (!rpt_valid && rpt_vec == '0));

  // R7: the vector is empty exactly when the strobe is low.
  a_r7_vec_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    !rpt_valid |-> (rpt_vec == '0));
  a_r7_strobe_has_bit: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |-> (rpt_vec != '0));

  // R7: only states flagged for reporting appear.
  a_r7_only_reporters: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rpt_vec & ~$past(rep_en)) == '0));

  // R2: an idle cycle is followed by no report.
  a_r2_no_report_idle: assert property (@(posedge clk) disable iff (rst)
    !sym_valid |=> !rpt_valid);

endmodule

// File: rtl/nfa_state_array.sv
module nfa_state_array #(
  parameter int N_STATES = 8,
  parameter int SYM_W    = 8,
  parameter int CFG_W    = 32,
  localparam int NSYM    = 1 << SYM_W,
  localparam int WORDS   = NSYM / CFG_W,
  localparam int IDX_W   = (N_STATES > 1) ? $clog2(N_STATES) : 1,
  localparam int WSEL_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sym_valid,
  input  logic                sym_first,
  input  logic [SYM_W-1:0]    sym_data,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_kind,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [WSEL_W-1:0]   cfg_word,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic                rpt_valid,
  output logic [N_STATES-1:0] rpt_vec
);

  logic [N_STATES-1:0][NSYM-1:0]     masks;
  logic [N_STATES-1:0][N_STATES-1:0] routes;
  logic [N_STATES-1:0][1:0]          modes;
  logic [N_STATES-1:0]               rep_en;
  logic [N_STATES-1:0]               active_vec;
  logic [N_STATES-1:0]               pred_en;
  logic [N_STATES-1:0]               match_vec;

  nfa_cfg_store #(
    .N_STATES (N_STATES),
    .SYM_W    (SYM_W),
    .CFG_W    (CFG_W)
  ) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_kind    (cfg_kind),
    .cfg_idx     (cfg_idx),
    .cfg_word    (cfg_word),
    .cfg_wdata   (cfg_wdata),
    .stream_busy (sym_valid),
    .masks       (masks),
    .routes      (routes),
    .modes       (modes),
    .rep_en      (rep_en)
  );

  nfa_route_net #(
    .N_STATES (N_STATES)
  ) u_route (
    .active  (active_vec),
    .routes  (routes),
    .pred_en (pred_en)
  );

  for (genvar i = 0; i < N_STATES; i++) begin : g_cell
    nfa_state_cell #(
      .SYM_W (SYM_W)
    ) u_cell (
      .clk       (clk),
      .rst       (rst),
      .sym_valid (sym_valid),
      .sym_first (sym_first),
      .sym_data  (sym_data),
      .mask      (masks[i]),
      .mode      (modes[i]),
      .pred_en   (pred_en[i]),
      .match     (match_vec[i]),
      .active_q  (active_vec[i])
    );
  end

  nfa_report #(
    .N_STATES (N_STATES)
  ) u_rpt (
    .clk       (clk),
    .rst       (rst),
    .sym_valid (sym_valid),
    .match     (match_vec),
    .rep_en    (rep_en),
    .rpt_valid (rpt_valid),
    .rpt_vec   (rpt_vec)
  );

  // R3: nothing matches without a symbol.
  a_r3_no_match_idle: assert property (@(posedge clk) disable iff (rst)
    !sym_valid |-> (match_vec == '0));

  // R1: reset clears every active flag.
  a_r1_active_reset: assert property (@(posedge clk)
    rst |=> (active_vec == '0));

endmodule

// File: tb/nfa_state_array_bench.sv
`timescale 1ns/1ps
module nfa_state_array_bench;
  localparam int N   = 8;
  localparam int NV  = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sym_valid = 1'b0;
  logic        sym_first = 1'b0;
  logic [7:0]  sym_data = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [2:0]  cfg_idx = '0;
  logic [2:0]  cfg_word = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rpt_valid;
  logic [7:0]  rpt_vec;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  nfa_state_array u_nfa_state_array (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_first(sym_first),
    .sym_data(sym_data), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
    .rpt_valid(rpt_valid), .rpt_vec(rpt_vec)
  );

  // Entry: {valid, first, symbol, expected report vector}
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'd10, 8'h00},  // R4 first-symbol state 0 starts
    {1'b1, 1'b0, 8'd20, 8'h02},  // R5 0 -> 1
    {1'b1, 1'b0, 8'd30, 8'h44},  // R5 fan-out 1 -> 2 and 6
    {1'b1, 1'b0, 8'd30, 8'h04},  // R5 self loop on 2
    {1'b1, 1'b0, 8'd40, 8'h08},  // R4 all-input state 3
    {1'b0, 1'b0, 8'd00, 8'h00},  // R2 idle gap keeps state 3
    {1'b1, 1'b0, 8'd41, 8'h10},  // R3 3 -> 4 after gap
    {1'b1, 1'b0, 8'd40, 8'h08},  // R3 4 has no successor
    {1'b1, 1'b0, 8'd40, 8'h18},  // R3 two states match at once
    {1'b1, 1'b0, 8'd99, 8'h00},  // R7 state 5 matches but does not report
    {1'b1, 1'b0, 8'd99, 8'h40},  // R5 fan-in 5 -> 6
    {1'b1, 1'b0, 8'd10, 8'h00},  // R4 first-symbol state idle mid-stream
    {1'b1, 1'b1, 8'd10, 8'h00},  // R6 restart
    {1'b1, 1'b1, 8'd20, 8'h00},  // R6 state 0 link dropped
    {1'b1, 1'b0, 8'd40, 8'h08},  // R3 stream continues
    {1'b1, 1'b1, 8'd41, 8'h00}   // R6 state 3 link dropped
  };

  task automatic check(input string req, input logic got_v, input logic [7:0] got,
                       input logic [7:0] exp);
    logic exp_v;
    exp_v = (exp != 8'h00);
    n_tests++;
    if (got_v !== exp_v || got !== exp) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b vec=%02h, expected valid=%0b vec=%02h",
               req, got_v, got, exp_v, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] k, input int idx, input int word,
                        input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = k; cfg_idx = idx[2:0];
    cfg_word = word[2:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_mask(input int idx, input logic [255:0] m);
    for (int w = 0; w < 8; w++) cfg_wr(2'b00, idx, w, m[w*32 +: 32]);
  endtask

  task automatic step(input logic v, input logic f, input logic [7:0] s,
                      input logic [7:0] exp, input string req);
    @(negedge clk);
    sym_valid = v; sym_first = f; sym_data = s;
    @(posedge clk);
    #1 check(req, rpt_valid, rpt_vec, exp);
  endtask

  task automatic go_idle();
    @(negedge clk);
    sym_valid = 1'b0; sym_first = 1'b0;
  endtask

  task automatic one_mask(input int idx, input int a, input int b);
    logic [255:0] m;
    m = '0;
    if (a >= 0) m[a] = 1'b1;
    if (b >= 0) m[b] = 1'b1;
    set_mask(idx, m);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset outputs", rpt_valid, rpt_vec, 8'h00);
    @(negedge clk);
    rst = 1'b0;

    // Masks
    one_mask(0, 10, -1);
    one_mask(1, 20, -1);
    one_mask(2, 30, -1);
    one_mask(3, 40, -1);
    one_mask(4, 40, 41);
    one_mask(5, 99, -1);
    one_mask(6, 30, 99);
    one_mask(7, 8'h55, -1);
    // Routes (row i, bit j: i enables j)
    cfg_wr(2'b01, 0, 0, 32'h02);
    cfg_wr(2'b01, 1, 0, 32'h44);
    cfg_wr(2'b01, 2, 0, 32'h04);
    cfg_wr(2'b01, 3, 0, 32'h10);
    cfg_wr(2'b01, 5, 0, 32'h40);
    // Attributes: [1:0] mode, [2] report
    cfg_wr(2'b10, 0, 0, 32'h1);
    cfg_wr(2'b10, 1, 0, 32'h4);
    cfg_wr(2'b10, 2, 0, 32'h4);
    cfg_wr(2'b10, 3, 0, 32'h6);
    cfg_wr(2'b10, 4, 0, 32'h4);
    cfg_wr(2'b10, 5, 0, 32'h2);
    cfg_wr(2'b10, 6, 0, 32'h4);
    cfg_wr(2'b10, 7, 0, 32'h4);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][17], VEC[k][16], VEC[k][15:8], VEC[k][7:0],
           $sformatf("R3/R5 vector %0d", k));
    end

    // R9: a write alongside a symbol is dropped
    step(1'b1, 1'b1, 8'h00, 8'h00, "R9 lead-in");
    @(negedge clk);
    sym_valid = 1'b1; sym_first = 1'b0; sym_data = 8'h00;
    cfg_we = 1'b1; cfg_kind = 2'b10; cfg_idx = 3'd7; cfg_wdata = 32'h6;
    @(posedge clk);
    #1 check("R9 colliding write cycle", rpt_valid, rpt_vec, 8'h00);
    @(negedge clk);
    cfg_we = 1'b0;
    step(1'b1, 1'b0, 8'h55, 8'h00, "R9 write discarded");
    go_idle();

    // R8/R4: same write while idle takes effect
    cfg_wr(2'b10, 7, 0, 32'h6);
    step(1'b1, 1'b0, 8'h55, 8'h80, "R8 attr write, R4 all-input");
    step(1'b1, 1'b0, 8'h55, 8'h80, "R4 all-input repeats");
    go_idle();
    cfg_wr(2'b10, 7, 0, 32'h7);
    step(1'b1, 1'b0, 8'h55, 8'h00, "R4 mode 11 needs activation");
    go_idle();
    // R8: kind 11 writes nothing
    cfg_wr(2'b11, 7, 0, 32'h6);
    step(1'b1, 1'b0, 8'h55, 8'h00, "R8 kind 11 ignored");
    go_idle();
    // R2: idle cycle after a reporting symbol
    cfg_wr(2'b10, 7, 0, 32'h6);
    step(1'b1, 1'b0, 8'h55, 8'h80, "R7 report before idle");
    step(1'b0, 1'b0, 8'h55, 8'h00, "R2 idle gives no report");

    // R1: reset mid-run clears outputs and configuration
    step(1'b1, 1'b0, 8'h55, 8'h80, "R7 report before reset");
    @(negedge clk);
    sym_valid = 1'b0; rst = 1'b1;
    @(posedge clk);
    #1 check("R1 reset clears report", rpt_valid, rpt_vec, 8'h00);
    @(negedge clk);
    rst = 1'b0;
    step(1'b1, 1'b0, 8'h55, 8'h00, "R1 config cleared (state 7)");
    step(1'b1, 1'b1, 8'd40, 8'h00, "R1 config cleared (state 3)");
    step(1'b1, 1'b0, 8'd10, 8'h00, "R1 config cleared (state 0)");
    go_idle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule